// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether a memory access that has already been translated may go ahead. A request carries the access kind (load, store or instruction fetch), the hart's current privilege level, three status controls (supervisor-user-access, modified-privilege enable and the saved previous privilege), whether supervisor mode is implemented, the translation mode (bare or paged), and the permission bits of the page-table entry that produced the translation. The entry also comes with a flag saying whether it was just fetched by a page-table walk or found in the translation cache.

The block returns one registered verdict per request. The verdict says whether translation is bypassed (physical equals virtual), whether the access faults and with which cause code, or whether the requester must walk the page table again before a fault can be decided. The request side has a valid/ready handshake. The verdict is held on the output until the consumer accepts it.

Top module: `page_perm_check`

## Requirements
- R1: A load (accType 0; code 3 is reserved and behaves as a load) to a page with pteR clear raises a fault with cause 13.
- R2: A store (accType 1) to a freshly walked page (pteFresh 1) with pteW clear raises a fault with cause 15.
- R3: A fetch (accType 2) to a page with pteX clear raises a fault with cause 12.
- R4: An access at user privilege (encoding 0) to a page with pteU clear faults.
- R5: An access at supervisor privilege (encoding 1; the reserved encoding 2 behaves the same) to a page with pteU set faults unless statSum is 1.
- R6: When several checks fail, exactly one fault is reported, with the cause of the access kind. A verdict with no fault carries cause 0.
- R7: Translation is bypassed (bypass 1, fault 0, rewalk 0) when sExtOn is 0, when the effective privilege is machine (encoding 3), or when pagedMode is 0 (bare).
- R8: For loads and stores with statMprv set, the effective privilege is statMpp. Fetches always use curPriv.
- R9: A store to a cached entry (pteFresh 0) with pteW clear, when not bypassed, returns rewalk 1 and fault 0 whatever the other checks say.
- R10: A request accepted on a clock edge produces respValid and its verdict after that edge. While respReady is low the verdict stays unchanged and reqReady is low.
- R11: Each accepted request yields exactly one accepted response. With respReady high and no new request, respValid is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request |
| accType | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved (load) |
| curPriv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| statSum | input | 1 | Supervisor may touch user pages |
| statMprv | input | 1 | Loads and stores use the saved privilege |
| statMpp | input | 2 | Saved previous privilege |
| sExtOn | input | 1 | Supervisor mode implemented |
| pagedMode | input | 1 | 1 paged translation, 0 bare |
| pteR | input | 1 | Entry readable |
| pteW | input | 1 | Entry writable |
| pteX | input | 1 | Entry executable |
| pteU | input | 1 | Entry user-accessible |
| pteFresh | input | 1 | 1 entry from a new walk, 0 from the cache |
| respValid | output | 1 | Verdict present |
| respReady | input | 1 | Consumer takes the verdict |
| bypass | output | 1 | Physical address equals virtual |
| fault | output | 1 | Access faults |
| faultCause | output | 4 | Cause code, 0 when no fault |
| rewalk | output | 1 | A fresh page-table walk is needed |

## Verification
The bench sweeps every legal combination of access kind, privilege, saved privilege and the nine single-bit controls. Each verdict is checked against a model written from the requirements. That sweep catches four kinds of error: a design that applies the saved privilege to fetches, one that faults on a cached store instead of asking for a rewalk, one that lets supervisor mode touch user pages with the sum bit clear, and one that keeps checking permissions under machine or bare mode. A separate sequence holds respReady low while new inputs arrive. It checks that the verdict does not slip to the newer request and that it drops after one accepted cycle. A design that overwrites its held result, or that repeats a response, fails there.

// File: rtl/pchk_pkg.sv
package pchk_pkg;
  parameter int CAUSE_W = 4;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_e;

  typedef enum logic [1:0] {
    PRV_USER  = 2'd0,
    PRV_SUPER = 2'd1,
    PRV_RSVD  = 2'd2,
    PRV_MACH  = 2'd3
  } privLvl_e;

  typedef struct packed {
    logic               bypass;
    logic               fault;
    logic [CAUSE_W-1:0] cause;
    logic               rewalk;
  } verdict_t;

  typedef struct packed {
    logic load;
    logic drop;
  } strobes_t;
endpackage

// File: rtl/perm_ctrl.sv
module perm_ctrl
  import pchk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reqValid,
  input  logic     respReady,
  output logic     reqReady,
  output logic     respValid,
  output strobes_t strb
);
  logic heldQ;

  // a new request may enter when nothing is held or the held verdict leaves now
  assign reqReady  = !heldQ || respReady;
  assign strb.load = reqValid && reqReady;
  assign strb.drop = heldQ && respReady && !strb.load;
  assign respValid = heldQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         heldQ <= 1'b0;
    else if (strb.load) heldQ <= 1'b1;
    else if (strb.drop) heldQ <= 1'b0;
  end
endmodule

// File: rtl/perm_dp.sv
module perm_dp
  import pchk_pkg::*;
#(
  parameter logic [CAUSE_W-1:0] CAUSE_FETCH = 4'd12,
  parameter logic [CAUSE_W-1:0] CAUSE_LOAD  = 4'd13,
  parameter logic [CAUSE_W-1:0] CAUSE_STORE = 4'd15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  strobes_t   strb,
  input  logic [1:0] accType,
  input  logic [1:0] curPriv,
  input  logic       statSum,
  input  logic       statMprv,
  input  logic [1:0] statMpp,
  input  logic       sExtOn,
  input  logic       pagedMode,
  input  logic       pteR,
  input  logic       pteW,
  input  logic       pteX,
  input  logic       pteU,
  input  logic       pteFresh,
  output verdict_t   verdictQ
);
  accKind_e kind;
  privLvl_e effPriv;
  logic     isFetch, isStore, permMiss, privMiss, needWalk, skipXlate;
  verdict_t nextV;

  always_comb begin
    kind    = accKind_e'(accType);
    isFetch = (kind == ACC_FETCH);
    isStore = (kind == ACC_STORE);
    // saved privilege applies to data accesses only
    effPriv = (statMprv && !isFetch) ? privLvl_e'(statMpp) : privLvl_e'(curPriv);
    skipXlate = !sExtOn || (effPriv == PRV_MACH) || !pagedMode;

    unique case (kind)
      ACC_FETCH: permMiss = !pteX;
      ACC_STORE: permMiss = !pteW;
      default:   permMiss = !pteR;
    endcase

    if (effPriv == PRV_USER) privMiss = !pteU;
    else                     privMiss = pteU && !statSum;

    needWalk = isStore && !pteW && !pteFresh;

    nextV = '0;
    if (skipXlate) begin
      nextV.bypass = 1'b1;
    end else if (needWalk) begin
      nextV.rewalk = 1'b1;
    end else if (permMiss || privMiss) begin
      nextV.fault = 1'b1;
      nextV.cause = isFetch ? CAUSE_FETCH : (isStore ? CAUSE_STORE : CAUSE_LOAD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         verdictQ <= '0;
    else if (strb.load) verdictQ <= nextV;
  end
endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
  import pchk_pkg::*;
#(
  parameter logic [CAUSE_W-1:0] CAUSE_FETCH = 4'd12,
  parameter logic [CAUSE_W-1:0] CAUSE_LOAD  = 4'd13,
  parameter logic [CAUSE_W-1:0] CAUSE_STORE = 4'd15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [1:0]         accType,
  input  logic [1:0]         curPriv,
  input  logic               statSum,
  input  logic               statMprv,
  input  logic [1:0]         statMpp,
  input  logic               sExtOn,
  input  logic               pagedMode,
  input  logic               pteR,
  input  logic               pteW,
  input  logic               pteX,
  input  logic               pteU,
  input  logic               pteFresh,
  output logic               respValid,
  input  logic               respReady,
  output logic               bypass,
  output logic               fault,
  output logic [CAUSE_W-1:0] faultCause,
  output logic               rewalk
);
  strobes_t strb;
  verdict_t verdictQ;

  perm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .respReady(respReady),
    .reqReady(reqReady), .respValid(respValid), .strb(strb)
  );

  perm_dp #(
    .CAUSE_FETCH(CAUSE_FETCH), .CAUSE_LOAD(CAUSE_LOAD), .CAUSE_STORE(CAUSE_STORE)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .accType(accType), .curPriv(curPriv),
    .statSum(statSum), .statMprv(statMprv), .statMpp(statMpp), .sExtOn(sExtOn),
    .pagedMode(pagedMode), .pteR(pteR), .pteW(pteW), .pteX(pteX), .pteU(pteU),
    .pteFresh(pteFresh), .verdictQ(verdictQ)
  );

  assign bypass     = verdictQ.bypass;
  assign fault      = verdictQ.fault;
  assign faultCause = verdictQ.cause;
  assign rewalk     = verdictQ.rewalk;
endmodule

// File: rtl/perm_check_sva.sv
module perm_check_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       reqValid,
  input logic       reqReady,
  input logic       respValid,
  input logic       respReady,
  input logic       bypass,
  input logic       fault,
  input logic [3:0] faultCause,
  input logic       rewalk
);
  // R9: a rewalk request never comes with a fault
  assert_walk_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> !(fault && rewalk));

  // R7: a bypassed verdict carries neither fault nor rewalk
  assert_bypass_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (respValid && bypass) |-> (!fault && !rewalk));

  // R6: a fault carries a nonzero cause, a clean verdict carries zero
  assert_cause_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> (fault == (faultCause != 4'd0)));

  // R10: stalled verdict holds
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (respValid && !respReady) |=> (respValid && $stable({bypass, fault, faultCause, rewalk})));

  // R10: no new request taken while a verdict is stalled
  assert_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (respValid && !respReady) |-> !reqReady);

  // R11: accepted verdict with no new request leaves
  assert_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (respValid && respReady && !(reqValid && reqReady)) |=> !respValid);
endmodule

bind page_perm_check perm_check_sva u_sva (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
  .respValid(respValid), .respReady(respReady), .bypass(bypass), .fault(fault),
  .faultCause(faultCause), .rewalk(rewalk)
);

// File: tb/page_perm_check_tb_top.sv
`timescale 1ns/1ps
module page_perm_check_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reqValid = 1'b0, respReady = 1'b0;
  logic [1:0] accType = '0, curPriv = '0, statMpp = '0;
  logic       statSum = 0, statMprv = 0, sExtOn = 0, pagedMode = 0;
  logic       pteR = 0, pteW = 0, pteX = 0, pteU = 0, pteFresh = 0;
  logic       reqReady, respValid, bypass, fault, rewalk;
  logic [3:0] faultCause;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  page_perm_check dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .accType(accType), .curPriv(curPriv), .statSum(statSum), .statMprv(statMprv),
    .statMpp(statMpp), .sExtOn(sExtOn), .pagedMode(pagedMode), .pteR(pteR),
    .pteW(pteW), .pteX(pteX), .pteU(pteU), .pteFresh(pteFresh),
    .respValid(respValid), .respReady(respReady), .bypass(bypass), .fault(fault),
    .faultCause(faultCause), .rewalk(rewalk)
  );

  // expected {bypass, fault, cause, rewalk} from the requirements
  function automatic logic [6:0] model(input logic [1:0] a, input logic [1:0] c,
      input logic [1:0] mp, input logic mv, input logic su, input logic so,
      input logic pg, input logic r, input logic w, input logic x, input logic u,
      input logic fr);
    logic [1:0] ep;
    logic pm, vm, fl;
    logic [3:0] cs;
    ep = (mv && a != 2'd2) ? mp : c;                  // R8
    if (!so || ep == 2'd3 || !pg) return {1'b1, 1'b0, 4'd0, 1'b0}; // R7
    if (a == 2'd1 && !w && !fr) return {1'b0, 1'b0, 4'd0, 1'b1};   // R9
    pm = (a == 2'd2) ? !x : (a == 2'd1) ? !w : !r;    // R1 R2 R3
    vm = (ep == 2'd0) ? !u : (u && !su);              // R4 R5
    fl = pm || vm;
    cs = !fl ? 4'd0 : (a == 2'd2) ? 4'd12 : (a == 2'd1) ? 4'd15 : 4'd13; // R6
    return {1'b0, fl, cs, 1'b0};
  endfunction

  task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic setIn(input logic [1:0] a, input logic [1:0] c, input logic [1:0] mp,
      input logic [8:0] b);
    accType = a; curPriv = c; statMpp = mp;
    {statMprv, statSum, sExtOn, pagedMode, pteR, pteW, pteX, pteU, pteFresh} = b;
  endtask

  function automatic logic [6:0] curExp();
    return model(accType, curPriv, statMpp, statMprv, statSum, sExtOn, pagedMode,
                 pteR, pteW, pteX, pteU, pteFresh);
  endfunction

  initial begin
    logic [6:0] expA, expB;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset", {respValid, reqReady, bypass, fault, faultCause[0], rewalk, 1'b0},
          {1'b0, 1'b1, 5'b0});

    // exhaustive sweep, one request per cycle
    respReady = 1'b1;
    for (int a = 0; a < 3; a++)
      for (int ci = 0; ci < 3; ci++)
        for (int mi = 0; mi < 3; mi++)
          for (int b = 0; b < 512; b++) begin
            logic [1:0] pv [3];
            pv[0] = 2'd0; pv[1] = 2'd1; pv[2] = 2'd3;
            setIn(a[1:0], pv[ci], pv[mi], b[8:0]);
            expA = curExp();
            reqValid = 1'b1;
            @(negedge clk);
            check("R1-model sweep R2 R3 R4 R5 R6 R7 R8 R9",
                  {bypass, fault, faultCause, rewalk}, expA);
            check("R10 valid after accept", {6'd0, respValid}, 7'd1);
          end

    // reserved access code behaves as a load: R1
    setIn(2'd3, 2'd1, 2'd0, 9'b0_0_1_1_0_1_1_0_1);
    @(negedge clk);
    check("R1 reserved kind", {bypass, fault, faultCause, rewalk}, {1'b0, 1'b1, 4'd13, 1'b0});

    // R11: single response when request stops
    reqValid = 1'b0;
    @(negedge clk);
    check("R11 one cycle", {6'd0, respValid}, 7'd0);

    // R10 backpressure: A stalls, B waits
    respReady = 1'b0;
    setIn(2'd2, 2'd0, 2'd0, 9'b0_0_1_1_1_1_0_1_1); // fetch, no X -> fault 12
    expA = curExp();
    reqValid = 1'b1;
    @(negedge clk);
    setIn(2'd1, 2'd1, 2'd0, 9'b0_1_1_1_1_0_1_1_0); // store, cached, no W -> rewalk
    expB = curExp();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 hold", {bypass, fault, faultCause, rewalk}, expA);
      check("R10 stall ready", {5'd0, respValid, reqReady}, 7'b0000010);
    end
    respReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check("R10 next verdict R9", {bypass, fault, faultCause, rewalk}, expB);
    @(negedge clk);
    check("R11 drop", {6'd0, respValid}, 7'd0);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule